// File: doc/BRIEF.md
# OTP Fuse Controller Register Front-End

This block is a register-mapped controller for a small one-time-programmable array of 32-bit fuse words. Software first asks for array power and waits for the power status to follow. It then issues commands through one command register. A command can copy a fuse word into its shadow, OR new bits into a fuse word, or OR bits into the permanent-lock area. While a command runs, a busy bit is set. A program that is refused raises a failure bit.

Software reads words from their shadow copies, which are mapped one word per address. Per-word error and disturbed flags are grouped 32 words to a register, and so are three sticky lock bitmaps: one blocks shadow reloads, one blocks software writes to the shadow, and one blocks programming. Inside the block the fuse array is a behavioural model. It starts blank at reset and takes a fixed number of cycles for each operation.

Top module: `fuse_ctl`

## Requirements
- R1: Status bit 5 (power) takes the value of configuration bit 0 (offset 0x000) exactly PWR_DELAY cycles after the configuration write, in both directions.
- R2: A command written to offset 0x004 while status bit 5 is low, or while status bit 3 is high, is dropped. It starts nothing, changes no fuse, shadow or flag, and does not restart the running command.
- R3: An accepted command holds status bit 3 (busy) high for exactly OP_LATENCY cycles, starting with the cycle that follows the command write.
- R4: Command value `i` (bits 9:8 = 00) is a shadow read. It copies fuse word `i` into the shadow at 0x200 + 4*i and clears the error and disturbed flags of word `i`.
- R5: With the data written first to offset 0x008, command value `i | 0x100` is a program. It ORs that data into fuse word `i`, so fuse bits are never cleared. The shadow copy keeps its old value until the next shadow read.
- R6: A program of a word whose program lock (bank base 0x064) or permanent lock (bank base 0x04C) is set does not change the fuse. It sets status bit 4 (fail) and the word's error flag (bank base 0x034). The fail bit clears when the next command is accepted.
- R7: A shadow read of a word whose shadow-read lock (bank base 0x094) is set leaves the shadow unchanged and sets the word's disturbed flag (bank base 0x01C).
- R8: Per-word bits are banked: word `i` sits in the register at base + (i>>5)*4, bit i&31. Writing a one to the program, shadow-write or shadow-read lock banks sets that bit. Writing a zero never clears it.
- R9: A bus write to 0x200 + 4*i replaces shadow word `i`, unless its shadow-write lock (bank base 0x07C) is set, in which case the shadow is unchanged.
- R10: Command value `b | 0x300` ORs the program data into permanent-lock bank `b`. A bank number of NUM_WORDS/32 or more sets the fail bit instead.
- R11: After reset, every register, fuse word, shadow word, flag and lock reads zero.
- R12: A read or program command whose word index is NUM_WORDS or more is dropped, and busy stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |

## Verification
The assertions check the following on every cycle:
- Lock bits only ever go up, and fuse bits never clear.
- Power changes only towards the requested value.
- Busy starts only when power is up, and busy runs uninterrupted.
- A locked program always ends with the fail bit set.
- A read blocked by its lock leaves the shadow copy alone.

Some properties can only be shown by the bench scenarios: the exact power and busy cycle counts, the OR accumulation through the shadow copy, dropping a command issued while unpowered or busy, bank and bit placement, and the out-of-range bank failure.

// File: rtl/fuse_pkg.sv
package fuse_pkg;
   typedef enum logic [1:0] {
      OP_READ = 2'b00,
      OP_PROG = 2'b01,
      OP_NONE = 2'b10,
      OP_LOCK = 2'b11
   } fuse_op_e;

   localparam logic [11:0] OFS_CONF    = 12'h000;
   localparam logic [11:0] OFS_CMD     = 12'h004;
   localparam logic [11:0] OFS_WDATA   = 12'h008;
   localparam logic [11:0] OFS_STATUS  = 12'h00C;
   localparam logic [11:0] OFS_DISTURB = 12'h01C;
   localparam logic [11:0] OFS_ERROR   = 12'h034;
   localparam logic [11:0] OFS_PERMLK  = 12'h04C;
   localparam logic [11:0] OFS_PROGLK  = 12'h064;
   localparam logic [11:0] OFS_SWLK    = 12'h07C;
   localparam logic [11:0] OFS_SRLK    = 12'h094;

   function automatic fuse_op_e decode_op(input logic [1:0] enc);
      case (enc)
         2'b00:   return OP_READ;
         2'b01:   return OP_PROG;
         2'b11:   return OP_LOCK;
         default: return OP_NONE;
      endcase
   endfunction

   function automatic logic bank_hit(input logic [11:0] a, input logic [11:0] base,
                                     input int nb);
      logic [11:0] d;
      d = a - base;
      return (a >= base) && (d[1:0] == 2'b00) && (int'(d[11:2]) < nb);
   endfunction

   function automatic logic [7:0] bank_sel(input logic [11:0] a, input logic [11:0] base);
      logic [11:0] d;
      d = a - base;
      return d[9:2];
   endfunction
endpackage

// File: rtl/fuse_pwr_seq.sv
module fuse_pwr_seq #(
   parameter int PWR_DELAY = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   output logic pwr
);
   localparam int CW = (PWR_DELAY > 2) ? $clog2(PWR_DELAY) : 1;

   if (PWR_DELAY < 2) begin : g_bad_delay
      $error("fuse_pwr_seq: PWR_DELAY must be at least 2");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         pwr   <= 1'b0;
      end else if (req != pwr) begin
         if (cnt_q == CW'(PWR_DELAY - 1)) begin
            pwr   <= req;
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end else begin
         cnt_q <= '0;
      end
   end

   AST_PWR_RISE_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwr) |-> req); // R1
   AST_PWR_FALL_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pwr) |-> !req); // R1
endmodule

// File: rtl/fuse_sticky_bits.sv
module fuse_sticky_bits #(
   parameter int NUM_WORDS = 64
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sw_we,
   input  logic [7:0]           sw_bank,
   input  logic [31:0]          sw_mask,
   input  logic                 hw_we,
   input  logic [7:0]           hw_bank,
   input  logic [31:0]          hw_mask,
   output logic [NUM_WORDS-1:0] bits
);
   localparam int NBANK = NUM_WORDS / 32;

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            bits[b*32 +: 32] <= '0;
         end else begin
            bits[b*32 +: 32] <= bits[b*32 +: 32]
               | ((sw_we && int'(sw_bank) == b) ? sw_mask : 32'h0)
               | ((hw_we && int'(hw_bank) == b) ? hw_mask : 32'h0);
         end
      end
   end

   AST_STICKY_NEVER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(bits) & ~bits) == '0)); // R8
endmodule

// File: rtl/fuse_engine.sv
module fuse_engine
   import fuse_pkg::*;
#(
   parameter int NUM_WORDS  = 64,
   parameter int OP_LATENCY = 6
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         powered,
   input  logic                         cmd_valid,
   input  fuse_op_e                     cmd_op,
   input  logic [7:0]                   cmd_idx,
   input  logic [31:0]                  prog_data,
   input  logic [NUM_WORDS-1:0]         sr_lock,
   input  logic [NUM_WORDS-1:0]         sw_lock,
   input  logic [NUM_WORDS-1:0]         prog_lock,
   input  logic [NUM_WORDS-1:0]         perm_lock,
   input  logic                         sh_we,
   input  logic [$clog2(NUM_WORDS)-1:0] sh_widx,
   input  logic [31:0]                  sh_wdata,
   input  logic [$clog2(NUM_WORDS)-1:0] sh_ridx,
   output logic [31:0]                  sh_rdata,
   output logic                         busy,
   output logic                         fail,
   output logic [NUM_WORDS-1:0]         err_bits,
   output logic [NUM_WORDS-1:0]         dist_bits,
   output logic                         perm_set_we,
   output logic [7:0]                   perm_set_bank,
   output logic [31:0]                  perm_set_mask
);
   localparam int WI    = $clog2(NUM_WORDS);
   localparam int CW    = (OP_LATENCY > 2) ? $clog2(OP_LATENCY) : 1;
   localparam int NBANK = NUM_WORDS / 32;

   if (OP_LATENCY < 2) begin : g_bad_lat
      $error("fuse_engine: OP_LATENCY must be at least 2");
   end

   logic [31:0]     fuse_q   [NUM_WORDS];
   logic [31:0]     shadow_q [NUM_WORDS];
   logic [CW-1:0]   cnt_q;
   fuse_op_e        op_q;
   logic [7:0]      idx_q;
   logic [31:0]     data_q;
   logic [WI-1:0]   w;
   logic            accept, done, idx_ok, locked;

   assign idx_ok = (cmd_op == OP_LOCK) || (int'(cmd_idx) < NUM_WORDS);
   assign accept = cmd_valid && powered && !busy && (cmd_op != OP_NONE) && idx_ok;
   assign done   = busy && (cnt_q == CW'(OP_LATENCY - 1));
   assign w      = idx_q[WI-1:0];
   assign locked = prog_lock[w] | perm_lock[w];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         fail      <= 1'b0;
         cnt_q     <= '0;
         op_q      <= OP_NONE;
         idx_q     <= '0;
         data_q    <= '0;
         err_bits  <= '0;
         dist_bits <= '0;
         for (int i = 0; i < NUM_WORDS; i++) begin
            fuse_q[i]   <= '0;
            shadow_q[i] <= '0;
         end
      end else begin
         if (sh_we && !sw_lock[sh_widx]) shadow_q[sh_widx] <= sh_wdata;
         if (accept) begin
            busy   <= 1'b1;
            fail   <= 1'b0;
            cnt_q  <= '0;
            op_q   <= cmd_op;
            idx_q  <= cmd_idx;
            data_q <= prog_data;
         end else if (busy) begin
            cnt_q <= cnt_q + 1'b1;
         end
         if (done) begin
            busy <= 1'b0;
            case (op_q)
               OP_READ: begin
                  if (sr_lock[w]) begin
                     dist_bits[w] <= 1'b1;
                  end else begin
                     shadow_q[w]  <= fuse_q[w];
                     err_bits[w]  <= 1'b0;
                     dist_bits[w] <= 1'b0;
                  end
               end
               OP_PROG: begin
                  if (locked) begin
                     fail        <= 1'b1;
                     err_bits[w] <= 1'b1;
                  end else begin
                     fuse_q[w] <= fuse_q[w] | data_q;
                  end
               end
               OP_LOCK: if (int'(idx_q) >= NBANK) fail <= 1'b1;
               default: ;
            endcase
         end
      end
   end

   assign sh_rdata      = shadow_q[sh_ridx];
   assign perm_set_we   = done && (op_q == OP_LOCK) && (int'(idx_q) < NBANK);
   assign perm_set_bank = idx_q;
   assign perm_set_mask = data_q;

   logic [NUM_WORDS*32-1:0] fuse_flat, shadow_flat;
   for (genvar i = 0; i < NUM_WORDS; i++) begin : g_flat
      assign fuse_flat[i*32 +: 32]   = fuse_q[i];
      assign shadow_flat[i*32 +: 32] = shadow_q[i];
   end

   AST_FUSE_NEVER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(fuse_flat) & ~fuse_flat) == '0)); // R5
   AST_START_NEEDS_POWER: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(powered)); // R2
   AST_BUSY_UNBROKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy); // R3
   AST_LOCKED_PROG_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
      (done && op_q == OP_PROG && locked) |=> fail); // R6
   AST_SR_LOCK_KEEPS_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
      (done && op_q == OP_READ && sr_lock[w] && !sh_we) |=> $stable(shadow_flat)); // R7
endmodule

// File: rtl/fuse_ctl.sv
module fuse_ctl
   import fuse_pkg::*;
#(
   parameter int NUM_WORDS  = 64,
   parameter int PWR_DELAY  = 4,
   parameter int OP_LATENCY = 6
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_we,
   input  logic [11:0] bus_addr,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata
);
   localparam int NBANK = NUM_WORDS / 32;
   localparam int WI    = $clog2(NUM_WORDS);

   if ((NUM_WORDS % 32) != 0 || NUM_WORDS < 32 || NUM_WORDS > 128) begin : g_bad_words
      $error("fuse_ctl: NUM_WORDS must be a multiple of 32 between 32 and 128");
   end

   logic        conf_q;
   logic [31:0] wdata_q;
   logic        pwr, busy, fail, sh_hit;
   logic [31:0] sh_rdata;
   logic [NUM_WORDS-1:0] lk_sr, lk_sw, lk_prog, lk_perm, err_bits, dist_bits;
   logic        perm_we;
   logic [7:0]  perm_bank;
   logic [31:0] perm_mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         conf_q  <= 1'b0;
         wdata_q <= '0;
      end else if (bus_we) begin
         if (bus_addr == OFS_CONF)  conf_q  <= bus_wdata[0];
         if (bus_addr == OFS_WDATA) wdata_q <= bus_wdata;
      end
   end

   assign sh_hit = (bus_addr[11:9] == 3'b001) && (bus_addr[1:0] == 2'b00)
                   && (int'(bus_addr[8:2]) < NUM_WORDS);

   fuse_pwr_seq #(.PWR_DELAY(PWR_DELAY)) u_pwr (
      .clk(clk), .rst_n(rst_n), .req(conf_q), .pwr(pwr)
   );

   fuse_sticky_bits #(.NUM_WORDS(NUM_WORDS)) u_lk_sr (
      .clk(clk), .rst_n(rst_n),
      .sw_we(bus_we && bank_hit(bus_addr, OFS_SRLK, NBANK)),
      .sw_bank(bank_sel(bus_addr, OFS_SRLK)), .sw_mask(bus_wdata),
      .hw_we(1'b0), .hw_bank(8'h00), .hw_mask(32'h0), .bits(lk_sr)
   );
   fuse_sticky_bits #(.NUM_WORDS(NUM_WORDS)) u_lk_sw (
      .clk(clk), .rst_n(rst_n),
      .sw_we(bus_we && bank_hit(bus_addr, OFS_SWLK, NBANK)),
      .sw_bank(bank_sel(bus_addr, OFS_SWLK)), .sw_mask(bus_wdata),
      .hw_we(1'b0), .hw_bank(8'h00), .hw_mask(32'h0), .bits(lk_sw)
   );
   fuse_sticky_bits #(.NUM_WORDS(NUM_WORDS)) u_lk_prog (
      .clk(clk), .rst_n(rst_n),
      .sw_we(bus_we && bank_hit(bus_addr, OFS_PROGLK, NBANK)),
      .sw_bank(bank_sel(bus_addr, OFS_PROGLK)), .sw_mask(bus_wdata),
      .hw_we(1'b0), .hw_bank(8'h00), .hw_mask(32'h0), .bits(lk_prog)
   );
   fuse_sticky_bits #(.NUM_WORDS(NUM_WORDS)) u_lk_perm (
      .clk(clk), .rst_n(rst_n),
      .sw_we(1'b0), .sw_bank(8'h00), .sw_mask(32'h0),
      .hw_we(perm_we), .hw_bank(perm_bank), .hw_mask(perm_mask), .bits(lk_perm)
   );

   fuse_engine #(.NUM_WORDS(NUM_WORDS), .OP_LATENCY(OP_LATENCY)) u_engine (
      .clk(clk), .rst_n(rst_n), .powered(pwr),
      .cmd_valid(bus_we && bus_addr == OFS_CMD),
      .cmd_op(decode_op(bus_wdata[9:8])), .cmd_idx(bus_wdata[7:0]),
      .prog_data(wdata_q),
      .sr_lock(lk_sr), .sw_lock(lk_sw), .prog_lock(lk_prog), .perm_lock(lk_perm),
      .sh_we(bus_we && sh_hit), .sh_widx(bus_addr[WI+1:2]), .sh_wdata(bus_wdata),
      .sh_ridx(bus_addr[WI+1:2]), .sh_rdata(sh_rdata),
      .busy(busy), .fail(fail), .err_bits(err_bits), .dist_bits(dist_bits),
      .perm_set_we(perm_we), .perm_set_bank(perm_bank), .perm_set_mask(perm_mask)
   );

   always_comb begin
      bus_rdata = 32'h0;
      if (bus_addr == OFS_CONF)        bus_rdata = {31'h0, conf_q};
      else if (bus_addr == OFS_WDATA)  bus_rdata = wdata_q;
      else if (bus_addr == OFS_STATUS) bus_rdata = {26'h0, pwr, fail, busy, 3'b000};
      else if (sh_hit)                 bus_rdata = sh_rdata;
      else if (bank_hit(bus_addr, OFS_DISTURB, NBANK))
         bus_rdata = dist_bits[{bank_sel(bus_addr, OFS_DISTURB), 5'b0} +: 32];
      else if (bank_hit(bus_addr, OFS_ERROR, NBANK))
         bus_rdata = err_bits[{bank_sel(bus_addr, OFS_ERROR), 5'b0} +: 32];
      else if (bank_hit(bus_addr, OFS_PERMLK, NBANK))
         bus_rdata = lk_perm[{bank_sel(bus_addr, OFS_PERMLK), 5'b0} +: 32];
      else if (bank_hit(bus_addr, OFS_PROGLK, NBANK))
         bus_rdata = lk_prog[{bank_sel(bus_addr, OFS_PROGLK), 5'b0} +: 32];
      else if (bank_hit(bus_addr, OFS_SWLK, NBANK))
         bus_rdata = lk_sw[{bank_sel(bus_addr, OFS_SWLK), 5'b0} +: 32];
      else if (bank_hit(bus_addr, OFS_SRLK, NBANK))
         bus_rdata = lk_sr[{bank_sel(bus_addr, OFS_SRLK), 5'b0} +: 32];
   end
endmodule

// File: tb/fuse_ctl_bench.sv
module fuse_ctl_bench;
   localparam int NUM_WORDS = 64;
   localparam int PWR_DELAY = 4;
   localparam int OP_LAT    = 6;
   localparam logic [11:0] A_CONF = 12'h000, A_CMD = 12'h004, A_WDATA = 12'h008,
      A_STAT = 12'h00C, A_DIST = 12'h01C, A_ERR = 12'h034, A_PERM = 12'h04C,
      A_PROGLK = 12'h064, A_SWLK = 12'h07C, A_SRLK = 12'h094, A_SH = 12'h200;

   // {word index, program data, expected shadow after reload}
   localparam logic [71:0] VEC [6] = '{
      {8'd3,  32'h0000_00F0, 32'h0000_00F0},
      {8'd3,  32'h0F00_0000, 32'h0F00_00F0},
      {8'd40, 32'hA5A5_A5A5, 32'hA5A5_A5A5},
      {8'd63, 32'h8000_0001, 32'h8000_0001},
      {8'd0,  32'h1234_5678, 32'h1234_5678},
      {8'd40, 32'h5A5A_0000, 32'hFFFF_A5A5}
   };

   logic clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   int n_chk = 0, n_fail = 0;
   logic [31:0] model [NUM_WORDS];
   logic [31:0] v;

   always #10 clk = ~clk;

   fuse_ctl #(.NUM_WORDS(NUM_WORDS), .PWR_DELAY(PWR_DELAY), .OP_LATENCY(OP_LAT)) u_fuse_ctl (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
      bus_addr = a; #1; d = bus_rdata;
   endtask

   task automatic chk_reg(input string tag, input logic [11:0] a, input logic [31:0] exp);
      logic [31:0] d;
      bus_rd(a, d);
      chk(tag, d, exp);
   endtask

   task automatic wait_idle();
      logic [31:0] s;
      for (int i = 0; i < 50; i++) begin
         bus_rd(A_STAT, s);
         if (!s[3]) break;
         @(negedge clk);
      end
   endtask

   task automatic run_cmd(input logic [31:0] c);
      bus_wr(A_CMD, c);
      wait_idle();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired before the test completed");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      int n;
      for (int i = 0; i < NUM_WORDS; i++) model[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk_reg("R11 status", A_STAT, 32'h0);
      chk_reg("R11 conf", A_CONF, 32'h0);
      chk_reg("R11 shadow 5", A_SH + 12'd20, 32'h0);
      chk_reg("R11 error bank1", A_ERR + 12'd4, 32'h0);
      // R2 commands while unpowered are dropped
      bus_wr(A_WDATA, 32'hFFFF_FFFF);
      bus_wr(A_CMD, 32'h105);
      chk_reg("R2 unpowered no busy", A_STAT, 32'h0);
      // R1 power-up delay
      bus_wr(A_CONF, 32'h1);
      n = 0;
      for (int i = 0; i < 20; i++) begin
         bus_rd(A_STAT, v);
         if (v[5]) break;
         n++;
         @(negedge clk);
      end
      chk("R1 power-up cycles", n, PWR_DELAY);
      run_cmd(32'h005);
      chk_reg("R2 unpowered program left fuse blank", A_SH + 12'd20, 32'h0);
      // R3 busy duration
      bus_wr(A_CMD, 32'h001);
      n = 0;
      for (int i = 0; i < 20; i++) begin
         bus_rd(A_STAT, v);
         if (!v[3]) break;
         if (i == 1) begin
            bus_wdata = 32'h0000_FFFF;  // R2 program while busy, dropped
            bus_addr = A_WDATA; bus_we = 1'b1; @(posedge clk); @(negedge clk);
            bus_addr = A_CMD; bus_wdata = 32'h102; @(posedge clk); @(negedge clk);
            bus_we = 1'b0;
            n += 2;
            continue;
         end
         n++;
         @(negedge clk);
      end
      chk("R3 busy cycles", n, OP_LAT);
      run_cmd(32'h002);
      chk_reg("R2 busy program dropped", A_SH + 12'd8, 32'h0);
      // R12 out-of-range index
      bus_wr(A_CMD, 32'h040);
      chk_reg("R12 index 64 ignored", A_STAT, 32'h20);
      // R4/R5 vector table
      for (int k = 0; k < 6; k++) begin
         logic [7:0] idx;
         idx = VEC[k][71:64];
         bus_wr(A_WDATA, VEC[k][63:32]);
         run_cmd({22'h0, 2'b01, idx});
         chk_reg("R5 shadow unchanged after program", A_SH + {2'b0, idx, 2'b0}, model[idx]);
         chk_reg("R5 program status clean", A_STAT, 32'h20);
         run_cmd({24'h0, idx});
         model[idx] = VEC[k][31:0];
         chk_reg("R4 reload shows OR of programs", A_SH + {2'b0, idx, 2'b0}, model[idx]);
      end
      // R8 sticky program lock on word 40 (bank 1, bit 8)
      bus_wr(A_PROGLK + 12'd4, 32'h0000_0100);
      chk_reg("R8 lock set", A_PROGLK + 12'd4, 32'h0000_0100);
      bus_wr(A_PROGLK + 12'd4, 32'h0);
      chk_reg("R8 zero write keeps lock", A_PROGLK + 12'd4, 32'h0000_0100);
      bus_wr(A_PROGLK + 12'd4, 32'h0000_0200);
      chk_reg("R8 second bit accumulates", A_PROGLK + 12'd4, 32'h0000_0300);
      // R6 locked program fails
      bus_wr(A_WDATA, 32'h0000_0001);
      run_cmd(32'h128);
      chk_reg("R6 fail bit", A_STAT, 32'h30);
      chk_reg("R6 error flag word 40", A_ERR + 12'd4, 32'h0000_0100);
      run_cmd(32'h028);
      chk_reg("R6 fuse unchanged", A_SH + 12'd160, 32'hFFFF_A5A5);
      chk_reg("R6 fail cleared by next command", A_STAT, 32'h20);
      chk_reg("R4 reload clears error", A_ERR + 12'd4, 32'h0);
      // R10 permanent lock programming
      bus_wr(A_WDATA, 32'h0000_0002);
      run_cmd(32'h300);
      chk_reg("R10 perm lock bank0", A_PERM, 32'h0000_0002);
      chk_reg("R10 lock program ok", A_STAT, 32'h20);
      run_cmd(32'h101);
      chk_reg("R6 perm-locked word 1 fails", A_STAT, 32'h30);
      run_cmd(32'h302);
      chk_reg("R10 bank 2 out of range fails", A_STAT, 32'h30);
      // R7 shadow-read lock on word 3
      bus_wr(A_SRLK, 32'h0000_0008);
      bus_wr(A_WDATA, 32'h0000_0001);
      run_cmd(32'h103);
      run_cmd(32'h003);
      chk_reg("R7 shadow kept", A_SH + 12'd12, 32'h0F00_00F0);
      chk_reg("R7 disturbed flag", A_DIST, 32'h0000_0008);
      // R9 software shadow write and its lock
      bus_wr(A_SH, 32'h0000_DEAD);
      chk_reg("R9 shadow write", A_SH, 32'h0000_DEAD);
      bus_wr(A_SWLK, 32'h0000_0001);
      bus_wr(A_SH, 32'h0000_BEEF);
      chk_reg("R9 locked shadow write ignored", A_SH, 32'h0000_DEAD);
      // R1 power-down delay
      bus_wr(A_CONF, 32'h0);
      n = 0;
      for (int i = 0; i < 20; i++) begin
         bus_rd(A_STAT, v);
         if (!v[5]) break;
         n++;
         @(negedge clk);
      end
      chk("R1 power-down cycles", n, PWR_DELAY);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule